// File: doc/BRIEF.md
# Frame-Synchronized Serial Control Register Port

This block is the control port of a video front end. A host shifts commands in on a data line paired with a separate serial clock, in the synchronous shift format of a classic microcontroller UART mode 0: 8-bit words, least significant bit first, each bit taken on the rising edge of the serial clock. Each command is a pair of words. The first word is an address that selects one of three control registers, and the second word is the value for that register.

Received values do not reach the outputs directly. Each value goes into a shadow buffer that belongs to the addressed register. A vertical-sync pulse copies all three shadow buffers into the active registers in one clock, so new settings only take effect at a frame boundary. The same pulse is the only event that brings the serial receiver out of its undefined power-up condition. A synchronous reset exists for simulation only. After reset the receiver behaves as if its state were unknown, and it ignores serial traffic until the first vertical-sync pulse.

The serial clock and data are brought into the system clock domain by two-flop synchronizers. The vertical-sync input is taken as already synchronous to the system clock.

Top module: `frame_ctrl_port`

## Requirements
- R1: After reset all three active outputs read 0. Serial traffic that arrives before the first vertical-sync pulse writes nothing, so a following pulse still copies 0.
- R2: Words are 8 bits and the first bit received is bit 0. The address bytes 0xF0, 0xF1 and 0xF2 select the registers behind `cfg0_o`, `cfg1_o` and `cfg2_o` respectively.
- R3: A completed write changes only a shadow buffer. The active outputs hold their values until the next vertical-sync pulse.
- R4: On the first clock edge at which `vsync_i` is sampled low after being high, all three active outputs take the shadow values. This happens within one system clock of the fall.
- R5: After a vertical-sync pulse, the first rising serial-clock edge carries address bit 0. The data byte's bit 0 comes on the edge right after the eighth address bit.
- R6: A data byte that follows any address other than 0xF0 to 0xF2 is discarded, and no shadow buffer changes.
- R7: After a data byte, the next 8 bits are taken as a new address without any vertical-sync pulse, so commands can run back to back.
- R8: While `vsync_i` is high, serial edges are ignored. A command that is partly received when the pulse begins is abandoned, and address reception starts afresh after the fall.
- R9: Serial data is sampled at the rising serial-clock edge after two-flop synchronization. Each serial clock level must be held for at least three system clocks.
- R10: Several writes to the same address between two pulses leave the last value in the shadow buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset, for simulation only |
| ser_clk_i | input | 1 | Serial clock; bits are taken on its rising edge |
| ser_dat_i | input | 1 | Serial data, least significant bit first |
| vsync_i | input | 1 | Vertical-sync pulse; its falling edge loads the active registers |
| cfg0_o | output | 8 | Active register selected by address 0xF0 |
| cfg1_o | output | 8 | Active register selected by address 0xF1 |
| cfg2_o | output | 8 | Active register selected by address 0xF2 |

## Verification
The assertions assume that `vsync_i` is synchronous to the system clock and that each serial clock level lasts long enough for the synchronizers to see it. Under that assumption, a completed write is never flagged in the same cycle as a vertical-sync fall. The stimulus changes every input on the falling system clock edge, holds each serial clock phase for four system clocks and changes data only while the serial clock is low. It raises vertical sync only after the last write of a burst has had time to settle, except in the directed cases that cut a command short on purpose. The random commands use a fixed seed and mix valid and invalid addresses with random values. Vertical-sync pulses fall at random points between bursts.

// File: rtl/frame_ctrl_pkg.sv
// Shared constants and the receiver state type for the frame-synchronized
// control port. Assumes 8-bit serial words and three contiguous addresses.
package frame_ctrl_pkg;
    localparam int BYTE_W    = 8;
    localparam int NUM_REGS  = 3;
    localparam int SEL_W     = $clog2(NUM_REGS);
    localparam int CNT_W     = $clog2(BYTE_W);
    localparam int SYNC_LEN  = 2;
    localparam logic [BYTE_W-1:0] ADDR_BASE = 8'hF0;

    typedef enum logic [2:0] {
        ST_LOCKED,   // undefined until the first vertical pulse
        ST_HOLD,     // vertical pulse high, serial ignored
        ST_INIT,     // active registers just loaded, waiting first edge
        ST_ADDR,     // shifting address bits
        ST_DATA      // shifting data bits
    } fcp_state_e;
endpackage

// File: rtl/fcp_sync.sv
// Multi-stage synchronizer for a vector of asynchronous single-bit inputs.
// Assumes each input level lasts longer than STAGES system clocks.
module fcp_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain [STAGES];

    // First stage captures the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each further stage re-times the one before it.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/fcp_deser.sv
// Serial command receiver: turns rising serial edges into address and data
// bytes, LSB first, and issues one shadow write per valid command.
// Assumes bit_rise_i is a one-cycle pulse and vs_fall_i implies vs_hi_i low.
module fcp_deser
    import frame_ctrl_pkg::*;
#(
    parameter int W    = BYTE_W,
    parameter int NREG = NUM_REGS,
    parameter int SW   = SEL_W,
    parameter int CW   = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vs_hi_i,
    input  logic          vs_fall_i,
    input  logic          bit_rise_i,
    input  logic          bit_val_i,
    output logic          wr_en_o,
    output logic [SW-1:0] wr_sel_o,
    output logic [W-1:0]  wr_byte_o,
    output fcp_state_e    state_o
);
    fcp_state_e      state;
    logic [CW-1:0]   cnt;
    logic [W-1:0]    shreg;
    logic [W-1:0]    addr_q;
    logic [W-1:0]    shreg_nxt;
    logic [W-1:0]    offs;
    logic            hit;
    logic            last_bit;

    // Next shift value, address decode and end-of-word detect.
    always_comb begin
        shreg_nxt = {bit_val_i, shreg[W-1:1]};
        offs      = addr_q - ADDR_BASE;
        hit       = (offs < W'(NREG));
        last_bit  = (cnt == CW'(W - 1));
    end

    // Receiver state, bit counter, shift register and write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_LOCKED;
            cnt       <= '0;
            shreg     <= '0;
            addr_q    <= '0;
            wr_en_o   <= 1'b0;
            wr_sel_o  <= '0;
            wr_byte_o <= '0;
        end else begin
            wr_en_o <= 1'b0;
            if (vs_hi_i) begin
                state <= ST_HOLD;
                cnt   <= '0;
            end else if (vs_fall_i) begin
                state <= ST_INIT;
                cnt   <= '0;
            end else if (bit_rise_i && (state == ST_INIT || state == ST_ADDR
                                        || state == ST_DATA)) begin
                shreg <= shreg_nxt;
                cnt   <= cnt + 1'b1;
                if (state == ST_INIT) begin
                    state <= ST_ADDR;
                end else if (last_bit && state == ST_ADDR) begin
                    addr_q <= shreg_nxt;
                    state  <= ST_DATA;
                end else if (last_bit && state == ST_DATA) begin
                    state <= ST_ADDR;
                    if (hit) begin
                        wr_en_o   <= 1'b1;
                        wr_sel_o  <= offs[SW-1:0];
                        wr_byte_o <= shreg_nxt;
                    end
                end
            end
        end
    end

    assign state_o = state;
endmodule

// File: rtl/fcp_regbank.sv
// Shadow and active register pairs. A write touches one shadow buffer; a
// load pulse copies every shadow buffer into its active register at once.
module fcp_regbank
    import frame_ctrl_pkg::*;
#(
    parameter int W    = BYTE_W,
    parameter int NREG = NUM_REGS,
    parameter int SW   = SEL_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [SW-1:0]            wr_sel_i,
    input  logic [W-1:0]             wr_byte_i,
    input  logic                     load_i,
    output logic [NREG-1:0][W-1:0]   active_o
);
    logic [NREG-1:0][W-1:0] shadow;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Shadow buffer takes the byte addressed to it.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 shadow[g] <= '0;
            else if (wr_en_i && wr_sel_i == SW'(g))     shadow[g] <= wr_byte_i;
        end

        // Active register follows its shadow only on a load pulse.
        always_ff @(posedge clk) begin
            if (!rst_n)      active_o[g] <= '0;
            else if (load_i) active_o[g] <= shadow[g];
        end
    end
endmodule

// File: rtl/frame_ctrl_port.sv
// Top of the frame-synchronized serial control port. Synchronizes the
// serial lines, detects the vertical-sync fall and joins receiver and bank.
// Assumes vsync_i is synchronous to clk.
module frame_ctrl_port
    import frame_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic              vsync_i,
    output logic [BYTE_W-1:0] cfg0_o,
    output logic [BYTE_W-1:0] cfg1_o,
    output logic [BYTE_W-1:0] cfg2_o
);
    logic [1:0]                   ser_sync;
    logic                         sclk_prev;
    logic                         bit_rise;
    logic                         vs_q;
    logic                         vs_fall;
    logic                         wr_en;
    logic [SEL_W-1:0]             wr_sel;
    logic [BYTE_W-1:0]            wr_byte;
    fcp_state_e                   fsm_state;
    logic [NUM_REGS-1:0][BYTE_W-1:0] active;

    fcp_sync #(.WIDTH(2), .STAGES(SYNC_LEN)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ser_dat_i, ser_clk_i}),
        .q_o   (ser_sync)
    );

    // Previous synchronized serial clock and vertical-sync level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            vs_q      <= 1'b0;
        end else begin
            sclk_prev <= ser_sync[0];
            vs_q      <= vsync_i;
        end
    end

    // Edge pulses used by the receiver and the bank.
    always_comb begin
        bit_rise = ser_sync[0] & ~sclk_prev;
        vs_fall  = vs_q & ~vsync_i;
    end

    fcp_deser i_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .vs_hi_i    (vsync_i),
        .vs_fall_i  (vs_fall),
        .bit_rise_i (bit_rise),
        .bit_val_i  (ser_sync[1]),
        .wr_en_o    (wr_en),
        .wr_sel_o   (wr_sel),
        .wr_byte_o  (wr_byte),
        .state_o    (fsm_state)
    );

    fcp_regbank i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_byte_i (wr_byte),
        .load_i    (vs_fall),
        .active_o  (active)
    );

    assign cfg0_o = active[0];
    assign cfg1_o = active[1];
    assign cfg2_o = active[2];
endmodule

// File: rtl/fcp_checker.sv
// Property checker for frame_ctrl_port, attached by bind. Assumes vsync_i
// is synchronous to clk and that the serial lines meet the timing in R9.
module fcp_checker
    import frame_ctrl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              vsync_i,
    input logic              vs_fall,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input fcp_state_e        state,
    input logic [BYTE_W-1:0] cfg0_o,
    input logic [BYTE_W-1:0] cfg1_o,
    input logic [BYTE_W-1:0] cfg2_o
);
    assert_locked_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCKED) |-> !wr_en);

    assert_outputs_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !vs_fall |=> $stable({cfg0_o, cfg1_o, cfg2_o}));

    assert_init_after_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vs_fall |=> (state == ST_INIT));

    assert_sel_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_sel < SEL_W'(NUM_REGS)));

    assert_back_to_address_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (state == ST_ADDR));

    assert_no_write_in_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_i |=> !wr_en);
endmodule

bind frame_ctrl_port fcp_checker i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .vsync_i (vsync_i),
    .vs_fall (vs_fall),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .state   (fsm_state),
    .cfg0_o  (cfg0_o),
    .cfg1_o  (cfg1_o),
    .cfg2_o  (cfg2_o)
);

// File: tb/test_frame_ctrl_port.sv
module test_frame_ctrl_port;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b1;
    logic       ser_dat = 1'b0;
    logic       vsync = 1'b0;
    logic [7:0] cfg0, cfg1, cfg2;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] shadow_m [3];
    logic [7:0] active_m [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_ctrl_port i_frame_ctrl_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk_i (ser_clk),
        .ser_dat_i (ser_dat),
        .vsync_i   (vsync),
        .cfg0_o    (cfg0),
        .cfg1_o    (cfg1),
        .cfg2_o    (cfg2)
    );

    // Register index for an address byte, or -1 when it selects nothing.
    function automatic int sel_of(input logic [7:0] a);
        if (a >= 8'hF0 && a <= 8'hF2) return int'(a - 8'hF0);
        return -1;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        check(req, "cfg0", cfg0, active_m[0]);
        check(req, "cfg1", cfg1, active_m[1]);
        check(req, "cfg2", cfg2, active_m[2]);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            ser_clk = 1'b0;
            ser_dat = b[i];
            repeat (HALF_BIT) @(negedge clk);
            ser_clk = 1'b1;
            repeat (HALF_BIT - 1) @(negedge clk);
        end
    endtask

    // One command; the model updates only when it is meant to land.
    task automatic send_cmd(input logic [7:0] a, input logic [7:0] d, input bit lands);
        send_bits(a, 8);
        send_bits(d, 8);
        repeat (2) @(negedge clk);
        if (lands && sel_of(a) >= 0) shadow_m[sel_of(a)] = d;
    endtask

    // Vertical pulse: outputs hold until the fall, then load within a clock.
    task automatic vs_pulse(input string req);
        @(negedge clk);
        vsync = 1'b1;
        repeat (3) @(negedge clk);
        check_outputs("R3 before fall");
        vsync = 1'b0;
        for (int k = 0; k < 3; k++) active_m[k] = shadow_m[k];
        @(negedge clk);
        check_outputs(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] a, d;
        void'($urandom(32'd1971));
        for (int k = 0; k < 3; k++) begin
            shadow_m[k] = 8'h00;
            active_m[k] = 8'h00;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_outputs("R1 reset");

        // R1: traffic before the first pulse is ignored.
        send_cmd(8'hF0, 8'hA5, 1'b0);
        vs_pulse("R1 locked write ignored");

        // R2/R5: one write per register, distinct bit patterns.
        send_cmd(8'hF0, 8'h01, 1'b1);
        send_cmd(8'hF1, 8'h80, 1'b1);
        send_cmd(8'hF2, 8'h3C, 1'b1);
        check_outputs("R3 shadow only");
        vs_pulse("R2 R5 address map");

        // R6: bad addresses drop their data; R7 stream stays aligned.
        send_cmd(8'hF3, 8'hFF, 1'b1);
        send_cmd(8'h0F, 8'hEE, 1'b1);
        send_cmd(8'hF1, 8'h5A, 1'b1);
        vs_pulse("R6 R7 discard and resync");

        // R10: last write to one address wins.
        send_cmd(8'hF2, 8'h11, 1'b1);
        send_cmd(8'hF2, 8'h22, 1'b1);
        send_cmd(8'hF2, 8'hC3, 1'b1);
        vs_pulse("R10 last write wins");

        // R8: partial command cut by a pulse, then a clean restart.
        send_bits(8'hF0, 5);
        vs_pulse("R8 partial aborted");
        send_cmd(8'hF0, 8'h96, 1'b1);
        vs_pulse("R8 R5 restart after abort");

        // R8: a full command sent while the pulse is high is ignored.
        @(negedge clk);
        vsync = 1'b1;
        send_cmd(8'hF1, 8'h77, 1'b0);
        vsync = 1'b0;
        for (int k = 0; k < 3; k++) active_m[k] = shadow_m[k];
        @(negedge clk);
        check_outputs("R8 ignored during pulse");
        vs_pulse("R8 shadow untouched");

        // R9 and mixed: random commands, pulses at random points.
        for (int it = 0; it < 40; it++) begin
            a = ($urandom_range(0, 4) == 0) ? 8'($urandom) : 8'hF0 + 8'($urandom_range(0, 2));
            d = 8'($urandom);
            send_cmd(a, d, 1'b1);
            if ($urandom_range(0, 3) == 0) vs_pulse("R9 R2 random");
        end
        vs_pulse("R4 final load");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule